// File: doc/BRIEF.md
# Multichannel ADC Scan Sequencer

This block is the byte-wide, register-mapped control logic in front of a 32-input sampling converter. Software programs a first and a last channel. The block then steps the input multiplexer channel by channel between them and collects one 16-bit result per channel. A scan starts on a write to the data port or on a periodic scan pulse. Each conversion waits for a programmable spacing interval of 5, 10, 15 or 20 µs, which is counted on a 10 MHz clock-enable input. The channel sequence wraps from channel 31 back to channel 0.

When a scan finishes, the block can raise a conversion interrupt. Software clears it through the control register. The newest sample is read back as two bytes. A busy flag covers every conversion and every settling period that follows a configuration write. A trigger that arrives while the block is busy is dropped, and a sticky overrun flag records it. The analog converter is modelled by a stub. After a fixed latency it returns a value that depends on the channel.

Top module: `adc_scan_seq`

## Requirements
- R1: The first-channel register (offset 2) and the last-channel register (offset 3) keep only bits 4:0 and read back with bits 7:5 at zero. Writing 0x80 to offset 2 reads back 0x00. Writing 0xFF to offset 3 reads back 0x1F.
- R2: Any write to offset 0 starts a scan. Bit 7 of offset 8 reads 1 from the next cycle until the data is ready. Offset 0 then reads the sample low byte and offset 1 reads the high byte. The stub sample for channel c is {3'b101, c, 3'b000, c}, so channel 5 gives 0x05 and 0xA5.
- R3: Offset 8 reads {busy, 1, 1, channel}. Bits 4:0 hold the current multiplexer channel and bits 6:5 read 1 for single-ended inputs.
- R4: The configuration register (offset 11) stores bits 5:0 and reads back {busy, 0, bits 5:0}. A write to it starts one settling interval with busy set. After 0x0C is written, the readback is 0x8C during settling and 0x0C afterwards.
- R5: Configuration bits 5:4 set the spacing before each conversion: 0 gives 200, 1 gives 150, 2 gives 100 and 3 gives 50 tick-enable cycles.
- R6: With the scan bit (offset 7, bit 2) set, one trigger converts every channel from the first to the last in ascending order, wrapping from 31 to 0. With the bit clear, only the first channel is converted.
- R7: When a scan completes and interrupt enable (write offset 9 bit 7) is set, a pending flag is set. It drives the irq pin and reads as offset 9 bit 7. With enable clear, completion sets nothing.
- R8: Writing offset 8 with bit 3 set clears the pending interrupt.
- R9: A scan_tick pulse starts a scan only while the scan-clock enable (offset 9 bit 1, read back at the same position) is set. Otherwise the pulse is ignored.
- R10: A trigger that arrives while busy is ignored and sets the sticky overrun flag (offset 7 read bit 4). Writing offset 7 with bit 1 set clears the flag.
- R11: After reset, offsets 0, 1, 2, 3, 7, 9 and 11 read 0x00, offset 8 reads 0x60, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | 10 MHz clock-enable pulse for the interval counter |
| scan_tick | input | 1 | Periodic scan trigger pulse |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| irq | output | 1 | Pending conversion interrupt |

## Verification
The assertions check on every cycle that:
- an accepted trigger raises busy on the next cycle;
- a trigger that arrives while busy sets the overrun flag;
- the channel advances by exactly one, modulo 32, between conversions of a scan;
- converter results arrive only while a conversion is outstanding;
- the interrupt rises only after a scan completion;
- the channel registers never expose their upper bits.

Only the bench scenarios can show the full behaviour. These cover the order of a whole channel sequence, including the wrap, the spacing for each interval code, the sample values, the settling readback, and the handling of a dropped or disabled trigger.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    localparam int CH_W   = 5;
    localparam int BYTE_W = 8;
    localparam int SMP_W  = 16;
    localparam int SEL_W  = 2;
    localparam int CFG_W  = 6;
    localparam int ADDR_W = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] A_SMP_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_SMP_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_LO_CH  = 4'd2;
    localparam logic [ADDR_W-1:0] A_HI_CH  = 4'd3;
    localparam logic [ADDR_W-1:0] A_SEQ    = 4'd7;
    localparam logic [ADDR_W-1:0] A_CTL    = 4'd8;
    localparam logic [ADDR_W-1:0] A_INT    = 4'd9;
    localparam logic [ADDR_W-1:0] A_CFG    = 4'd11;

    // bit positions
    localparam int SEQ_SCAN_BIT = 2;
    localparam int SEQ_CLR_BIT  = 1;
    localparam int SEQ_OVF_BIT  = 4;
    localparam int CTL_ACK_BIT  = 3;
    localparam int INT_EN_BIT   = 7;
    localparam int INT_CLK_BIT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETTLE = 2'd1,
        ST_WAIT   = 2'd2,
        ST_CONV   = 2'd3
    } seq_st_e;

    typedef struct packed {
        seq_st_e           st;
        logic [CH_W-1:0]   ch;
        logic [SMP_W-1:0]  smp;
    } ctrl_t;

    typedef struct packed {
        logic [CH_W-1:0]  lo;
        logic [CH_W-1:0]  hi;
        logic [CFG_W-1:0] cfg;
        logic             scan_en;
        logic             irq_en;
        logic             clk_en;
        logic             irq_pend;
        logic             ovf;
    } regs_t;
endpackage

// File: rtl/adc_interval_timer.sv
module adc_interval_timer
    import adc_scan_pkg::*;
#(
    parameter int STEP_TICKS = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             start,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int MAX_TICKS = STEP_TICKS * (1 << SEL_W);
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             run_d, run_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit = CNT_W'(STEP_TICKS * ((1 << SEL_W) - int'(sel)));
        cnt_d = cnt_q;
        run_d = run_q;
        done  = 1'b0;
        if (start) begin
            run_d = 1'b1;
            cnt_d = limit;
        end else if (run_q && tick_en) begin
            if (cnt_q == CNT_W'(1)) begin
                done  = 1'b1;
                run_d = 1'b0;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    // R5: an interval never ends before it was started and counted
    assert_done_when_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_q && cnt_q != '0));
endmodule

// File: rtl/adc_conv_stub.sv
module adc_conv_stub
    import adc_scan_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  ch,
    output logic             valid,
    output logic [SMP_W-1:0] data
);
    localparam int LAT_W = $clog2(LAT + 1);
    localparam int PAD_W = SMP_W / 2 - CH_W;

    logic [LAT_W-1:0] cnt_d, cnt_q;
    logic             bsy_d, bsy_q;
    logic [CH_W-1:0]  ch_d, ch_q;

    always_comb begin
        cnt_d = cnt_q;
        bsy_d = bsy_q;
        ch_d  = ch_q;
        valid = 1'b0;
        if (start) begin
            cnt_d = LAT_W'(LAT);
            bsy_d = 1'b1;
            ch_d  = ch;
        end else if (bsy_q) begin
            if (cnt_q <= LAT_W'(1)) begin
                valid = 1'b1;
                bsy_d = 1'b0;
            end else begin
                cnt_d = cnt_q - LAT_W'(1);
            end
        end
        data = {PAD_W'(5), ch_q, PAD_W'(0), ch_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bsy_q <= 1'b0;
            ch_q  <= '0;
        end else begin
            cnt_q <= cnt_d;
            bsy_q <= bsy_d;
            ch_q  <= ch_d;
        end
    end
endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
    import adc_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger,
    input  logic             settle_req,
    input  logic             scan_en,
    input  logic [CH_W-1:0]  lo_ch,
    input  logic [CH_W-1:0]  hi_ch,
    input  logic             timer_done,
    input  logic             conv_valid,
    input  logic [SMP_W-1:0] conv_data,
    output logic             timer_start,
    output logic             conv_start,
    output logic [CH_W-1:0]  cur_ch,
    output logic             busy,
    output logic             scan_done,
    output logic             overrun_hit,
    output logic [SMP_W-1:0] sample
);
    ctrl_t           c_d, c_q;
    logic [CH_W-1:0] last_ch;

    always_comb begin
        c_d         = c_q;
        timer_start = 1'b0;
        conv_start  = 1'b0;
        scan_done   = 1'b0;
        last_ch     = scan_en ? hi_ch : lo_ch;
        overrun_hit = trigger && (c_q.st != ST_IDLE);
        case (c_q.st)
            ST_IDLE: begin
                if (trigger) begin
                    c_d.ch      = lo_ch;
                    c_d.st      = ST_WAIT;
                    timer_start = 1'b1;
                end else if (settle_req) begin
                    c_d.st      = ST_SETTLE;
                    timer_start = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (timer_done) c_d.st = ST_IDLE;
            end
            ST_WAIT: begin
                if (timer_done) begin
                    conv_start = 1'b1;
                    c_d.st     = ST_CONV;
                end
            end
            ST_CONV: begin
                if (conv_valid) begin
                    c_d.smp = conv_data;
                    if (c_q.ch == last_ch) begin
                        c_d.st    = ST_IDLE;
                        scan_done = 1'b1;
                    end else begin
                        c_d.ch      = c_q.ch + CH_W'(1);
                        c_d.st      = ST_WAIT;
                        timer_start = 1'b1;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
        cur_ch = c_q.ch;
        busy   = (c_q.st != ST_IDLE);
        sample = c_q.smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, ch: '0, smp: '0};
        else        c_q <= c_d;
    end

    assert_trigger_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && c_q.st == ST_IDLE) |=> busy);

    assert_result_in_conv_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |-> (c_q.st == ST_CONV));

    assert_channel_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_CONV && conv_valid && c_q.ch != last_ch)
            |=> (c_q.ch == $past(c_q.ch) + CH_W'(1)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adc_scan_pkg::*;
#(
    parameter int STEP_TICKS   = 50,
    parameter int CONV_LAT     = 4,
    parameter bit SINGLE_ENDED = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              scan_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int CH_PAD = BYTE_W - CH_W;

    regs_t            r_d, r_q;
    logic             trigger, settle_req;
    logic             timer_start, timer_done;
    logic             conv_start, conv_valid;
    logic [SMP_W-1:0] conv_data, sample;
    logic [CH_W-1:0]  cur_ch;
    logic             busy, scan_done, overrun_hit;
    logic             wdata_unused;

    assign wdata_unused = bus_wdata[6];

    assign trigger    = (bus_wr && bus_addr == A_SMP_LO) || (scan_tick && r_q.clk_en);
    assign settle_req = bus_wr && bus_addr == A_CFG;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                A_LO_CH: r_d.lo = bus_wdata[CH_W-1:0];
                A_HI_CH: r_d.hi = bus_wdata[CH_W-1:0];
                A_SEQ: begin
                    r_d.scan_en = bus_wdata[SEQ_SCAN_BIT];
                    if (bus_wdata[SEQ_CLR_BIT]) r_d.ovf = 1'b0;
                end
                A_CTL: if (bus_wdata[CTL_ACK_BIT]) r_d.irq_pend = 1'b0;
                A_INT: begin
                    r_d.irq_en = bus_wdata[INT_EN_BIT];
                    r_d.clk_en = bus_wdata[INT_CLK_BIT];
                end
                A_CFG:   r_d.cfg = bus_wdata[CFG_W-1:0];
                default: ;
            endcase
        end
        if (overrun_hit)               r_d.ovf      = 1'b1;
        if (scan_done && r_q.irq_en)   r_d.irq_pend = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (bus_addr)
            A_SMP_LO: bus_rdata = sample[BYTE_W-1:0];
            A_SMP_HI: bus_rdata = sample[SMP_W-1:BYTE_W];
            A_LO_CH:  bus_rdata = {{CH_PAD{1'b0}}, r_q.lo};
            A_HI_CH:  bus_rdata = {{CH_PAD{1'b0}}, r_q.hi};
            A_SEQ:    bus_rdata = {3'b000, r_q.ovf, 1'b0, r_q.scan_en, 2'b00};
            A_CTL:    bus_rdata = {busy, SINGLE_ENDED, SINGLE_ENDED, cur_ch};
            A_INT:    bus_rdata = {r_q.irq_pend, 5'b00000, r_q.clk_en, 1'b0};
            A_CFG:    bus_rdata = {busy, 1'b0, r_q.cfg};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = r_q.irq_pend;

    adc_interval_timer #(.STEP_TICKS(STEP_TICKS)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .start   (timer_start),
        .sel     (r_q.cfg[5:4]),
        .done    (timer_done)
    );

    adc_conv_stub #(.LAT(CONV_LAT)) conv_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .ch    (cur_ch),
        .valid (conv_valid),
        .data  (conv_data)
    );

    adc_scan_ctrl ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .trigger     (trigger),
        .settle_req  (settle_req),
        .scan_en     (r_q.scan_en),
        .lo_ch       (r_q.lo),
        .hi_ch       (r_q.hi),
        .timer_done  (timer_done),
        .conv_valid  (conv_valid),
        .conv_data   (conv_data),
        .timer_start (timer_start),
        .conv_start  (conv_start),
        .cur_ch      (cur_ch),
        .busy        (busy),
        .scan_done   (scan_done),
        .overrun_hit (overrun_hit),
        .sample      (sample)
    );

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trigger && busy) |=> r_q.ovf);

    assert_irq_after_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(scan_done));

    assert_irq_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTL && bus_wdata[CTL_ACK_BIT] && !scan_done) |=> !irq);

    assert_chan_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_LO_CH || bus_addr == A_HI_CH) |-> (bus_rdata[7:5] == 3'b000));
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
    localparam int STEP = 50;
    localparam int LAT  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       scan_tick = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    adc_scan_seq #(.STEP_TICKS(STEP), .CONV_LAT(LAT)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .scan_tick (scan_tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int cyc);
        logic [7:0] s;
        cyc = 0;
        rd(4'd8, s);
        while (s[7] && cyc < 20000) begin
            cyc++;
            rd(4'd8, s);
        end
    endtask

    task automatic t_reset_state;
        logic [7:0] v;
        rd(4'd0, v);  check("R11 sample lo", v, 8'h00);
        rd(4'd1, v);  check("R11 sample hi", v, 8'h00);
        rd(4'd2, v);  check("R11 first ch", v, 8'h00);
        rd(4'd3, v);  check("R11 last ch", v, 8'h00);
        rd(4'd7, v);  check("R11 seq", v, 8'h00);
        rd(4'd8, v);  check("R11 status", v, 8'h60);
        rd(4'd9, v);  check("R11 int", v, 8'h00);
        rd(4'd11, v); check("R11 cfg", v, 8'h00);
        check("R11 irq", irq, 0);
    endtask

    task automatic t_chan_regs;
        logic [7:0] v;
        wr(4'd2, 8'h80); rd(4'd2, v); check("R1 first ch 0x80", v, 8'h00);
        wr(4'd3, 8'hFF); rd(4'd3, v); check("R1 last ch 0xFF", v, 8'h1F);
    endtask

    task automatic t_settle;
        logic [7:0] v;
        int c;
        wr(4'd11, 8'h0C);
        rd(4'd11, v); check("R4 readback settling", v, 8'h8C);
        wait_idle(c);
        rd(4'd11, v); check("R4 readback settled", v, 8'h0C);
        check("R4 settle length ok", int'(c >= 4*STEP-3 && c <= 4*STEP+2), 1);
    endtask

    task automatic t_single_conv;
        logic [7:0] v;
        int c;
        wr(4'd11, 8'h30); wait_idle(c);
        wr(4'd2, 8'd5); wr(4'd7, 8'h00);
        wr(4'd0, 8'hFF);
        rd(4'd8, v); check("R2 busy after start", v[7], 1);
        wait_idle(c);
        rd(4'd0, v); check("R2 sample lo ch5", v, 8'h05);
        rd(4'd1, v); check("R2 sample hi ch5", v, 8'hA5);
        rd(4'd8, v); check("R3 status ch5", v, 8'h65);
    endtask

    task automatic t_interval;
        logic [7:0] v;
        int c;
        for (int sel = 0; sel < 4; sel++) begin
            int ticks;
            ticks = STEP * (4 - sel);
            wr(4'd11, 8'(sel << 4)); wait_idle(c);
            wr(4'd0, 8'h00);
            wait_idle(c);
            if (!(c >= ticks - 2 && c <= ticks + LAT + 2))
                $display("  R5 sel %0d measured %0d cycles", sel, c);
            check("R5 interval window", int'(c >= ticks - 2 && c <= ticks + LAT + 2), 1);
        end
        rd(4'd0, v); check("R5 sample after timing", v, 8'h05);
    endtask

    task automatic run_scan(input int lo, input int hi, output int seq[40], output int n);
        logic [7:0] s;
        int guard;
        wr(4'd2, 8'(lo)); wr(4'd3, 8'(hi)); wr(4'd7, 8'h04);
        wr(4'd0, 8'h00);
        n = 0; guard = 0;
        rd(4'd8, s);
        while (s[7] && guard < 20000) begin
            if (n == 0 || seq[n-1] != int'(s[4:0])) begin
                if (n < 40) seq[n] = int'(s[4:0]);
                n++;
            end
            guard++;
            rd(4'd8, s);
        end
    endtask

    task automatic t_wrap_scan;
        int seq[40];
        int n;
        logic [7:0] v;
        wr(4'd11, 8'h30); begin int c; wait_idle(c); end
        run_scan(30, 1, seq, n);
        check("R6 wrap count", n, 4);
        check("R6 wrap seq0", seq[0], 30);
        check("R6 wrap seq1", seq[1], 31);
        check("R6 wrap seq2", seq[2], 0);
        check("R6 wrap seq3", seq[3], 1);
        rd(4'd0, v); check("R6 wrap last lo", v, 8'h01);
        rd(4'd1, v); check("R6 wrap last hi", v, 8'hA1);
    endtask

    task automatic t_full_scan;
        int seq[40];
        int n;
        int ok;
        logic [7:0] v;
        run_scan(0, 31, seq, n);
        check("R6 full count", n, 32);
        ok = 1;
        for (int i = 0; i < 32; i++) if (seq[i] != i) ok = 0;
        check("R6 full order", ok, 1);
        rd(4'd0, v); check("R6 full last lo", v, 8'h1F);
        rd(4'd1, v); check("R6 full last hi", v, 8'hBF);
        wr(4'd7, 8'h00);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        int c;
        wr(4'd2, 8'd7);
        wr(4'd9, 8'h80);
        wr(4'd0, 8'h00); wait_idle(c);
        check("R7 irq set", irq, 1);
        rd(4'd9, v); check("R7 pending bit", v, 8'h80);
        wr(4'd8, 8'h08);
        check("R8 irq cleared", irq, 0);
        rd(4'd9, v); check("R8 pending bit", v, 8'h00);
        wr(4'd9, 8'h00);
        wr(4'd0, 8'h00); wait_idle(c);
        check("R7 disabled no irq", irq, 0);
    endtask

    task automatic t_scan_clock;
        logic [7:0] v;
        int c;
        wr(4'd2, 8'd9);
        @(negedge clk); scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
        rd(4'd8, v); check("R9 ignored busy", v[7], 0);
        rd(4'd0, v); check("R9 ignored sample", v, 8'h07);
        wr(4'd9, 8'h02);
        @(negedge clk); scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
        rd(4'd8, v); check("R9 started busy", v[7], 1);
        wait_idle(c);
        rd(4'd0, v); check("R9 sample ch9", v, 8'h09);
        rd(4'd9, v); check("R9 clk enable readback", v, 8'h02);
        wr(4'd9, 8'h00);
    endtask

    task automatic t_overrun;
        logic [7:0] v;
        int c;
        wr(4'd2, 8'd3);
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h00);
        rd(4'd7, v); check("R10 overrun set", v, 8'h10);
        wait_idle(c);
        check("R10 drop no extra conv", int'(c <= STEP + LAT + 2), 1);
        rd(4'd0, v); check("R10 sample ch3", v, 8'h03);
        rd(4'd7, v); check("R10 overrun sticky", v, 8'h10);
        wr(4'd7, 8'h02);
        rd(4'd7, v); check("R10 overrun cleared", v, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_chan_regs();
        t_settle();
        t_single_conv();
        t_interval();
        t_wrap_scan();
        t_full_scan();
        t_irq();
        t_scan_clock();
        t_overrun();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule